// File: doc/BRIEF.md
# Zone Access Map Table

This block keeps the recent demand and prefetch history of a set of memory zones for a map-driven prefetcher. The address space is split into fixed-size zones. The table holds a fixed number of zone maps and searches all of them at once, so it is fully associative. Each map stores a 2-bit history state for every cache line of its zone. A lookup names a zone tag and a line index. On a hit it advances the state of that line. On a miss it takes over the least recently looked-up map, clears it and records the access there.

One cycle after a lookup the block returns a hit flag and the complete state vector of the addressed zone. A pattern matcher can scan that vector for strides in any access order. A second input marks lines as prefetched once the issue logic has sent a request for them. This lets later demand hits on those lines be told apart as successful prefetches.

The default size is 52 maps of 256 lines each, so the returned vector is 512 bits wide. Line `i` occupies bits `[2i+1:2i]` of that vector.

Top module: `zone_access_map_table`

## Requirements
- R1: Reset invalidates every map. While reset is held and on the first cycle after it, `rsp_valid` and `rsp_hit` are 0. The first lookup of any zone after reset misses.
- R2: A lookup presented with `lk_valid` in one cycle gives `rsp_valid`=1 after the next rising edge. `rsp_hit` and `rsp_map` for that lookup appear in the same cycle. `rsp_valid` is 0 after a cycle with no lookup.
- R3: Line states are encoded as Init=2'b00, Access=2'b01, Prefetch=2'b10 and Success=2'b11. On a miss the allocated map starts with every line in Init. The accessed line is then set to Access, so the returned vector holds exactly one set bit.
- R4: A demand lookup that hits moves the addressed line from Init to Access and from Prefetch to Success. It leaves a line that is already in Access or Success unchanged.
- R5: A prefetch mark (`pf_valid`) for a zone that is present moves the named line from Init to Prefetch. A mark on a line in any other state is ignored.
- R6: A prefetch mark for a zone that no map holds is ignored. It allocates nothing and does not change which map is replaced next.
- R7: On a miss the replaced map is the one whose zone was looked up least recently. A lookup that hits makes its map the most recent. Prefetch marks do not change the recency order.
- R8: After reset, the first NUM_MAPS distinct zones that are looked up are all retained until a further distinct zone arrives.
- R9: When a lookup and a prefetch mark arrive in the same cycle, the mark is applied to the state left by the lookup. A mark on the line being accessed in Init is therefore ignored. A mark on a map that the same lookup evicts is also ignored. The returned vector includes both updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Demand lookup strobe |
| lk_tag | input | TAG_W | Zone tag of the lookup |
| lk_line | input | log2(LINES) | Line index within the zone |
| pf_valid | input | 1 | Prefetch mark strobe |
| pf_tag | input | TAG_W | Zone tag of the mark |
| pf_line | input | log2(LINES) | Line index of the mark |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | The previous lookup found its zone |
| rsp_map | output | 2*LINES | Updated state vector of the looked-up zone |

## Verification
Every lookup result, including the hit flag and the updated vector, is due on the clock edge that follows the cycle the lookup was driven in. Prefetch marks change only stored state and are observed through a later lookup. The bench drives inputs on the falling edge and samples the response one time unit after the next rising edge. It compares against a recency-stamp model of the table that advances once per driven cycle. Mid-run resets and idle cycles are checked at the same sampling point.

// File: rtl/zamt_pkg.sv
// Shared types and helpers for the zone access map table.
// Assumes the 2-bit line state encoding below is decoded by neighbours.
package zamt_pkg;

    typedef enum logic [1:0] {
        LS_INIT = 2'b00,
        LS_SEEN = 2'b01,
        LS_PREF = 2'b10,
        LS_USED = 2'b11
    } line_state_e;

    // Next state of a line after a demand access.
    function automatic logic [1:0] demand_next(input logic [1:0] cur);
        case (cur)
            LS_INIT: demand_next = LS_SEEN;
            LS_PREF: demand_next = LS_USED;
            default: demand_next = cur;
        endcase
    endfunction

    // Next state of a line after a prefetch mark.
    function automatic logic [1:0] mark_next(input logic [1:0] cur);
        mark_next = (cur == LS_INIT) ? LS_PREF : cur;
    endfunction

endpackage

// File: rtl/zamt_sel_or.sv
// One-hot AND-OR selector: returns the word whose select bit is set.
// Assumes at most one select bit is set; with none set it returns zero.
module zamt_sel_or #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N-1:0]        sel,
    input  logic [N-1:0][W-1:0] data,
    output logic [W-1:0]        out
);
    // Merge the masked words into one.
    always_comb begin
        out = '0;
        for (int i = 0; i < N; i++) begin
            out = out | (data[i] & {W{sel[i]}});
        end
    end
endmodule

// File: rtl/zamt_entry.sv
// One map of the table: valid flag, zone tag, recency rank and line states.
// Assumes the parent asserts lk_sel on at most one entry per cycle, and
// lk_alloc only together with lk_sel. A rank of 0 is the most recent.
module zamt_entry
    import zamt_pkg::*;
#(
    parameter int LINES     = 256,
    parameter int TAG_W     = 26,
    parameter int RANK_W    = 6,
    parameter int INIT_RANK = 0,
    localparam int IDX_W    = $clog2(LINES),
    localparam int MAP_W    = 2 * LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_sel,
    input  logic              lk_alloc,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [IDX_W-1:0]  lk_line,
    input  logic [RANK_W-1:0] tgt_rank,
    input  logic              pf_hit,
    input  logic [IDX_W-1:0]  pf_line,
    output logic              valid_q,
    output logic [TAG_W-1:0]  tag_q,
    output logic [RANK_W-1:0] rank_q,
    output logic [MAP_W-1:0]  map_nxt
);
    logic [MAP_W-1:0] map_q;
    logic [MAP_W-1:0] map_acc;

    // Apply the demand access first, then the prefetch mark on its result.
    always_comb begin
        map_acc = lk_alloc ? '0 : map_q;
        if (lk_sel) begin
            map_acc[2*lk_line +: 2] = demand_next(map_acc[2*lk_line +: 2]);
        end
        map_nxt = map_acc;
        if (pf_hit && !lk_alloc) begin
            map_nxt[2*pf_line +: 2] = mark_next(map_acc[2*pf_line +: 2]);
        end
    end

    // Store the map, its tag and its validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            map_q   <= '0;
        end else begin
            map_q <= map_nxt;
            if (lk_alloc) begin
                valid_q <= 1'b1;
                tag_q   <= lk_tag;
            end
        end
    end

    // Keep the recency rank: selected goes to 0, younger ones age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank_q <= RANK_W'(INIT_RANK);
        end else if (lk_sel) begin
            rank_q <= '0;
        end else if (lk_valid && (rank_q < tgt_rank)) begin
            rank_q <= rank_q + RANK_W'(1);
        end
    end
endmodule

// File: rtl/zone_access_map_table.sv
// Fully associative table of zone access maps with least-recently-used
// replacement. Lookups update one line and return the zone's full vector
// one cycle later; prefetch marks update a present zone only.
// Assumes NUM_MAPS >= 2 and LINES a power of two.
module zone_access_map_table
    import zamt_pkg::*;
#(
    parameter int NUM_MAPS = 52,
    parameter int LINES    = 256,
    parameter int TAG_W    = 26,
    localparam int IDX_W   = $clog2(LINES),
    localparam int MAP_W   = 2 * LINES,
    localparam int RANK_W  = $clog2(NUM_MAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [IDX_W-1:0] lk_line,
    input  logic             pf_valid,
    input  logic [TAG_W-1:0] pf_tag,
    input  logic [IDX_W-1:0] pf_line,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [MAP_W-1:0] rsp_map
);
    localparam logic [RANK_W-1:0] OLDEST = RANK_W'(NUM_MAPS - 1);

    logic [NUM_MAPS-1:0]             valid_q;
    logic [NUM_MAPS-1:0][TAG_W-1:0]  tag_q;
    logic [NUM_MAPS-1:0][RANK_W-1:0] rank_q;
    logic [NUM_MAPS-1:0][MAP_W-1:0]  map_nxt;
    logic [NUM_MAPS-1:0]             hit_vec;
    logic [NUM_MAPS-1:0]             old_vec;
    logic [NUM_MAPS-1:0]             pf_vec;
    logic [NUM_MAPS-1:0]             sel_vec;
    logic [NUM_MAPS-1:0]             alloc_vec;
    logic                            lk_hit;
    logic [RANK_W-1:0]               tgt_rank;
    logic [MAP_W-1:0]                sel_map;

    // Compare both request tags against every map and find the oldest map.
    always_comb begin
        for (int i = 0; i < NUM_MAPS; i++) begin
            hit_vec[i] = valid_q[i] && (tag_q[i] == lk_tag);
            pf_vec[i]  = pf_valid && valid_q[i] && (tag_q[i] == pf_tag);
            old_vec[i] = (rank_q[i] == OLDEST);
        end
    end

    // Choose the hit map, or the oldest map as victim on a miss.
    always_comb begin
        lk_hit    = |hit_vec;
        sel_vec   = lk_valid ? (lk_hit ? hit_vec : old_vec) : '0;
        alloc_vec = (lk_valid && !lk_hit) ? old_vec : '0;
    end

    zamt_sel_or #(.N(NUM_MAPS), .W(RANK_W)) u_rank_sel (
        .sel  (sel_vec),
        .data (rank_q),
        .out  (tgt_rank)
    );

    zamt_sel_or #(.N(NUM_MAPS), .W(MAP_W)) u_map_sel (
        .sel  (sel_vec),
        .data (map_nxt),
        .out  (sel_map)
    );

    for (genvar g = 0; g < NUM_MAPS; g++) begin : g_ent
        zamt_entry #(
            .LINES     (LINES),
            .TAG_W     (TAG_W),
            .RANK_W    (RANK_W),
            .INIT_RANK (g)
        ) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_valid (lk_valid),
            .lk_sel   (sel_vec[g]),
            .lk_alloc (alloc_vec[g]),
            .lk_tag   (lk_tag),
            .lk_line  (lk_line),
            .tgt_rank (tgt_rank),
            .pf_hit   (pf_vec[g]),
            .pf_line  (pf_line),
            .valid_q  (valid_q[g]),
            .tag_q    (tag_q[g]),
            .rank_q   (rank_q[g]),
            .map_nxt  (map_nxt[g])
        );
    end

    // Register the lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_map   <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_hit;
            rsp_map   <= sel_map;
        end
    end
endmodule

// File: rtl/zamt_chk.sv
// Property checker for the zone access map table, bound into the top.
// Observes ports and the tag-match and oldest-rank vectors.
module zamt_chk #(
    parameter int NUM_MAPS = 52,
    parameter int LINES    = 256,
    localparam int IDX_W   = $clog2(LINES),
    localparam int MAP_W   = 2 * LINES
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lk_valid,
    input logic [IDX_W-1:0]    lk_line,
    input logic                rsp_valid,
    input logic                rsp_hit,
    input logic [MAP_W-1:0]    rsp_map,
    input logic [NUM_MAPS-1:0] hit_vec,
    input logic [NUM_MAPS-1:0] old_vec
);
    logic [IDX_W-1:0] line_q;
    logic [1:0]       line_st;

    // Remember the line of the last lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= lk_line;
    end

    // State of that line in the returned vector.
    always_comb line_st = rsp_map[2*line_q +: 2];

    // R2
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid && !rsp_hit);
    // R4
    line_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> line_st[0]);
    // R3
    fresh_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> ($countones(rsp_map) == 1));
    // R7
    single_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    // R7
    one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(old_vec) == 1);
endmodule

bind zone_access_map_table zamt_chk #(
    .NUM_MAPS (NUM_MAPS),
    .LINES    (LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_line   (lk_line),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_map   (rsp_map),
    .hit_vec   (hit_vec),
    .old_vec   (old_vec)
);

// File: tb/zone_access_map_table_bench.sv
module zone_access_map_table_bench;
    localparam int NM = 4;
    localparam int LN = 16;
    localparam int TW = 8;
    localparam int IW = $clog2(LN);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [TW-1:0] lk_tag = '0;
    logic [IW-1:0] lk_line = '0;
    logic          pf_valid = 1'b0;
    logic [TW-1:0] pf_tag = '0;
    logic [IW-1:0] pf_line = '0;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [2*LN-1:0] rsp_map;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // model: recency stamps instead of ranks
    int mv [NM];
    int mt [NM];
    int ms [NM][LN];
    int stamp [NM];
    int now_t;

    always #2.5 clk = ~clk;

    zone_access_map_table #(.NUM_MAPS(NM), .LINES(LN), .TAG_W(TW)) u_zone_access_map_table (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_line(lk_line),
        .pf_valid(pf_valid), .pf_tag(pf_tag), .pf_line(pf_line),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_map(rsp_map)
    );

    task automatic model_reset();
        for (int i = 0; i < NM; i++) begin
            mv[i] = 0; mt[i] = 0; stamp[i] = -1 - i;
            for (int l = 0; l < LN; l++) ms[i][l] = 0;
        end
        now_t = 0;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lk_valid = 1'b0; pf_valid = 1'b0;
        @(posedge clk); #1;
        check("R1 valid in reset", 64'(rsp_valid), 64'd0);
        check("R1 hit in reset", 64'(rsp_hit), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(posedge clk); #1;
        check("R1 valid after reset", 64'(rsp_valid), 64'd0);
    endtask

    // One cycle of stimulus, model update and response check.
    task automatic step(input string req, input bit lv, input int lt, input int ll,
                        input bit pv, input int pt, input int pl);
        int h; int p; int v; int tgt; logic [2*LN-1:0] em; bit eh;
        @(negedge clk);
        lk_valid = lv; lk_tag = TW'(lt); lk_line = IW'(ll);
        pf_valid = pv; pf_tag = TW'(pt); pf_line = IW'(pl);
        h = -1; p = -1; v = -1; tgt = -1; eh = 1'b0;
        for (int i = 0; i < NM; i++) begin
            if (mv[i] != 0 && mt[i] == lt) h = i;
            if (mv[i] != 0 && mt[i] == pt) p = i;
        end
        if (lv) begin
            if (h >= 0) begin
                tgt = h; eh = 1'b1;
            end else begin
                v = 0;
                for (int i = 1; i < NM; i++) if (stamp[i] < stamp[v]) v = i;
                tgt = v; mv[v] = 1; mt[v] = lt;
                for (int l = 0; l < LN; l++) ms[v][l] = 0;
            end
            if (ms[tgt][ll] == 0) ms[tgt][ll] = 1;
            else if (ms[tgt][ll] == 2) ms[tgt][ll] = 3;
            now_t++;
            stamp[tgt] = now_t;
        end
        if (pv && p >= 0 && p != v && ms[p][pl] == 0) ms[p][pl] = 2;
        em = '0;
        if (tgt >= 0) for (int l = 0; l < LN; l++) em[2*l +: 2] = 2'(ms[tgt][l]);
        @(posedge clk); #1;
        check(req, 64'(rsp_valid), 64'(lv));
        if (lv) begin
            check(req, 64'(rsp_hit), 64'(eh));
            check(req, 64'(rsp_map), 64'(em));
        end
        lk_valid = 1'b0; pf_valid = 1'b0;
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        do_reset();
        // R1 R3: first lookup misses, fresh map
        step("R3", 1, 10, 3, 0, 0, 0);
        // R2: idle cycle gives no response
        step("R2", 0, 0, 0, 0, 0, 0);
        // R5: mark every line of zone 10, then observe
        for (int l = 0; l < LN; l++) step("R5", 0, 0, 0, 1, 10, l);
        step("R5", 1, 10, 0, 0, 0, 0);
        // R4: two demand passes over all lines
        for (int k = 0; k < 2; k++)
            for (int l = 0; l < LN; l++) step("R4", 1, 10, l, 0, 0, 0);
        // R6: marks to absent zones, then lookup misses
        step("R6", 0, 0, 0, 1, 99, 2);
        // R8: fill remaining maps, all retained
        step("R8", 1, 20, 1, 0, 0, 0);
        step("R8", 1, 30, 2, 0, 0, 0);
        step("R8", 1, 40, 3, 0, 0, 0);
        for (int t = 1; t <= 4; t++) step("R8", 1, t * 10, 5, 0, 0, 0);
        // R7: refresh 10, new zone evicts 20
        step("R7", 1, 10, 6, 0, 0, 0);
        step("R7", 1, 50, 0, 0, 0, 0);
        step("R7", 1, 20, 0, 0, 0, 0);
        step("R6", 1, 99, 0, 0, 0, 0);
        // R9: same-cycle lookup and mark
        step("R9", 1, 50, 5, 1, 50, 5);
        step("R9", 1, 50, 7, 1, 50, 8);
        step("R9", 1, 50, 8, 0, 0, 0);
        step("R9", 1, 77, 1, 1, 10, 9);
        step("R9", 1, 77, 9, 1, 77, 9);
        // R7: pseudo-random mixed traffic
        begin
            logic [15:0] lf = 16'hACE1;
            for (int n = 0; n < 600; n++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step("R7", lf[0] | lf[1], 1 + int'(lf[4:2]) % 6, int'(lf[8:5]),
                     lf[9], 1 + int'(lf[12:10]) % 6, int'(lf[15:12]));
            end
        end
        // R1: mid-run reset forgets all zones
        do_reset();
        step("R1", 1, 10, 0, 0, 0, 0);
        step("R1", 1, 50, 4, 0, 0, 0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule